// File: doc/BRIEF.md
# SPI status flag and request unit

This block keeps the sticky status flags of an SPI controller and turns them into one interrupt line and two DMA request lines. Six flags are tracked: transfer done, end of queue, transmit underflow, transmit fill request, receive overflow and receive drain request. A seventh bit shows whether the controller is running. Transfer-done, end-of-queue and transmit-underflow are set by one-cycle event pulses from the shifter. The fill and drain requests follow the FIFO occupancy levels. Receive overflow is set by the block's own check on each incoming word.

Software clears a flag by writing a one to its bit of the status word. A request-enable word uses the same bit positions. Two extra select bits send the fill and drain requests to a DMA channel instead of the interrupt line, and a DMA acknowledge clears the flag it serves.

The block also decides what happens to a word that arrives from the shifter. When the receive FIFO has room, the word is pushed. When the FIFO is full, an overwrite enable chooses between replacing stored data and dropping the word. There is no back-pressure on the incoming word: it is always taken in the cycle it is offered, either pushed, used as a replacement or dropped. The FIFO storage and the shifter live outside the block.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the status word is zero, all enables and selects are zero, and irq, both DMA requests, rx_push and rx_replace are low.
- R2: Status bits 1 (transfer done), 2 (end of queue) and 3 (transmit underflow) are set by their event pulse. They stay set until a status write has a one at their position. A zero written there has no effect, and a pulse in the same cycle as a clear leaves the bit set.
- R3: Bit 4 (fill request) is set in every cycle where tx_level < DEPTH. Bit 6 (drain request) is set in every cycle where rx_level != 0. A clear in a cycle forces the bit to zero for the next cycle, and the bit sets again one cycle later if its condition still holds.
- R4: The enable word uses the same positions as the status word (bits 1..6). irq is the OR of every enabled flag that is routed to interrupt.
- R5: Enable bit 7 routes the fill request and enable bit 8 routes the drain request. A value of 1 sends the flag to tx_dma_req or rx_dma_req instead of irq; a value of 0 sends it to irq.
- R6: While a flag's enable bit is 0, its select bit has no effect: the flag raises neither irq nor a DMA request.
- R7: tx_dma_ack clears the fill flag, and rx_dma_ack clears the drain flag, only while that flag is enabled and routed to DMA. Otherwise the acknowledge is ignored.
- R8: Status bit 0 equals run_i delayed by one cycle. It never raises irq, writing it has no effect, and enable bit 0 always reads as zero.
- R9: A word arriving with rx_level == DEPTH sets bit 5 (receive overflow) under either policy. rx_push is asserted only while the FIFO is not full. rx_replace is asserted for a word that arrives at a full FIFO while rx_ovwr_en is 1; with rx_ovwr_en at 0 that word is dropped.
- R10: Status bits, irq and the DMA requests reflect a stimulus one clock after it. rx_push and rx_replace follow their inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Controller running level |
| done_evt_i | input | 1 | Transfer-done pulse |
| eoq_evt_i | input | 1 | End-of-queue pulse |
| tx_uflow_evt_i | input | 1 | Transmit underflow pulse |
| tx_level_i | input | LW | Transmit FIFO occupancy |
| rx_level_i | input | LW | Receive FIFO occupancy |
| rx_word_i | input | 1 | Incoming word offered this cycle |
| rx_ovwr_en_i | input | 1 | Overwrite policy when the receive FIFO is full |
| st_wr_i | input | 1 | Status write strobe (write one to clear) |
| st_wdata_i | input | 7 | Status write data |
| en_wr_i | input | 1 | Enable word write strobe |
| en_wdata_i | input | 9 | Enable word: bits 1..6 enables, 7 and 8 DMA selects |
| tx_dma_ack_i | input | 1 | Fill-request DMA acknowledge |
| rx_dma_ack_i | input | 1 | Drain-request DMA acknowledge |
| status_o | output | 7 | Status word |
| irq_o | output | 1 | Interrupt request |
| tx_dma_req_o | output | 1 | Fill DMA request |
| rx_dma_req_o | output | 1 | Drain DMA request |
| rx_push_o | output | 1 | Push the incoming word into the receive FIFO |
| rx_replace_o | output | 1 | Replace stored data with the incoming word |

## Verification
Every flag, irq and both DMA requests come from registers. Their response to a stimulus is therefore due one clock later. rx_push and rx_replace are combinational and are due in the same cycle as rx_word. The bench drives its inputs just after a falling edge and advances its reference model at the next rising edge. It samples at the falling edge that follows, so a registered result is compared exactly one edge after its cause. Inputs are still held at that point, which lets the same sample check the combinational receive decision.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int STW = 7;   // status word width
  localparam int ENW = 9;   // enable word width (enables + two selects)
  localparam int B_RUN  = 0;
  localparam int B_DONE = 1;
  localparam int B_EOQ  = 2;
  localparam int B_UFL  = 3;
  localparam int B_FILL = 4;
  localparam int B_OVF  = 5;
  localparam int B_DRN  = 6;
  localparam int B_FSEL = 7;
  localparam int B_DSEL = 8;

  function automatic bit is_level_flag(int idx);
    return (idx == B_FILL) || (idx == B_DRN);
  endfunction
endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell #(
  parameter bit LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  generate
    if (LEVEL) begin : g_level
      always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (clr_i) flag_q <= 1'b0;
        else            flag_q <= flag_q | set_i;
      end
      // R3: a clear always empties the flag for one cycle
      a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);
    end else begin : g_event
      always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (flag_q & ~clr_i) | set_i;
      end
      // R2: a set flag without a clear stays set
      a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
      // R2: an event pulse is never lost
      a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    end
  endgenerate

  assign flag_o = flag_q;
endmodule

// File: rtl/spi_rx_guard.sv
module spi_rx_guard #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_i,
  input  logic [LW-1:0] level_i,
  input  logic          ovwr_en_i,
  output logic          push_o,
  output logic          replace_o,
  output logic          ovf_evt_o
);
  logic full;

  assign full      = (int'(level_i) >= DEPTH);
  assign push_o    = word_i & ~full;
  assign replace_o = word_i & full & ovwr_en_i;
  assign ovf_evt_o = word_i & full;

  // R9: a word is never both pushed and used as a replacement
  a_r9_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_o && replace_o));
  // R9: under the discard policy nothing is written into a full FIFO
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_o && !ovwr_en_i) |-> !(push_o || replace_o));
endmodule

// File: rtl/spi_req_route.sv
module spi_req_route
  import spi_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] stat_i,
  input  logic [ENW-1:0] en_i,
  output logic           irq_o,
  output logic           tx_dma_o,
  output logic           rx_dma_o
);
  logic [STW-1:0] to_irq;

  always_comb begin
    to_irq = stat_i & en_i[STW-1:0];
    to_irq[B_RUN] = 1'b0;
    if (en_i[B_FSEL]) to_irq[B_FILL] = 1'b0;
    if (en_i[B_DSEL]) to_irq[B_DRN]  = 1'b0;
  end

  assign irq_o    = |to_irq;
  assign tx_dma_o = stat_i[B_FILL] & en_i[B_FILL] & en_i[B_FSEL];
  assign rx_dma_o = stat_i[B_DRN]  & en_i[B_DRN]  & en_i[B_DSEL];

  // R6: a disabled request never reaches a DMA line
  a_r6_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i[B_FILL] |-> !tx_dma_o);
  a_r6_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i[B_DRN] |-> !rx_dma_o);
  // R8: the running bit alone never raises an interrupt
  a_r8_run_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i[STW-1:1] == '0) |-> !irq_o);
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           done_evt_i,
  input  logic           eoq_evt_i,
  input  logic           tx_uflow_evt_i,
  input  logic [LW-1:0]  tx_level_i,
  input  logic [LW-1:0]  rx_level_i,
  input  logic           rx_word_i,
  input  logic           rx_ovwr_en_i,
  input  logic           st_wr_i,
  input  logic [STW-1:0] st_wdata_i,
  input  logic           en_wr_i,
  input  logic [ENW-1:0] en_wdata_i,
  input  logic           tx_dma_ack_i,
  input  logic           rx_dma_ack_i,
  output logic [STW-1:0] status_o,
  output logic           irq_o,
  output logic           tx_dma_req_o,
  output logic           rx_dma_req_o,
  output logic           rx_push_o,
  output logic           rx_replace_o
);
  logic [ENW-1:0]   en_q;
  logic             run_q;
  logic [STW-1:1]   flag_set;
  logic [STW-1:1]   flag_clr;
  logic [STW-1:1]   flags;
  logic             ovf_evt;
  logic             tx_dma_hit;
  logic             rx_dma_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (en_wr_i) en_q <= en_wdata_i & ~(ENW'(1) << B_RUN);
    end
  end

  spi_rx_guard #(.DEPTH(DEPTH)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_i    (rx_word_i),
    .level_i   (rx_level_i),
    .ovwr_en_i (rx_ovwr_en_i),
    .push_o    (rx_push_o),
    .replace_o (rx_replace_o),
    .ovf_evt_o (ovf_evt)
  );

  assign tx_dma_hit = tx_dma_ack_i & en_q[B_FILL] & en_q[B_FSEL];
  assign rx_dma_hit = rx_dma_ack_i & en_q[B_DRN]  & en_q[B_DSEL];

  always_comb begin
    flag_set         = '0;
    flag_set[B_DONE] = done_evt_i;
    flag_set[B_EOQ]  = eoq_evt_i;
    flag_set[B_UFL]  = tx_uflow_evt_i;
    flag_set[B_FILL] = (int'(tx_level_i) < DEPTH);
    flag_set[B_OVF]  = ovf_evt;
    flag_set[B_DRN]  = (rx_level_i != '0);
    flag_clr         = {STW-1{st_wr_i}} & st_wdata_i[STW-1:1];
    flag_clr[B_FILL] = flag_clr[B_FILL] | tx_dma_hit;
    flag_clr[B_DRN]  = flag_clr[B_DRN]  | rx_dma_hit;
  end

  generate
    for (genvar g = 1; g < STW; g++) begin : g_flag
      spi_flag_cell #(.LEVEL(is_level_flag(g))) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set[g]),
        .clr_i  (flag_clr[g]),
        .flag_o (flags[g])
      );
    end
  endgenerate

  assign status_o = {flags, run_q};

  spi_req_route u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_i   (status_o),
    .en_i     (en_q),
    .irq_o    (irq_o),
    .tx_dma_o (tx_dma_req_o),
    .rx_dma_o (rx_dma_req_o)
  );

  // R7: an acknowledge on a DMA-routed enabled fill request empties it
  a_r7_tx_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_ack_i && en_q[B_FILL] && en_q[B_FSEL]) |=> !status_o[B_FILL]);
  a_r7_rx_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dma_ack_i && en_q[B_DRN] && en_q[B_DSEL]) |=> !status_o[B_DRN]);
  // R9: an arrival at a full FIFO marks overflow under either policy
  a_r9_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_i && int'(rx_level_i) >= DEPTH) |=> status_o[B_OVF]);
  // R8: the running bit follows run_i one cycle later
  a_r8_run_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_o[B_RUN] == $past(run_i)));
endmodule

// File: tb/spi_irq_unit_test.sv
module spi_irq_unit_test;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 0, done_evt_i = 0, eoq_evt_i = 0, tx_uflow_evt_i = 0;
  logic [LW-1:0] tx_level_i = '0, rx_level_i = '0;
  logic rx_word_i = 0, rx_ovwr_en_i = 0, st_wr_i = 0, en_wr_i = 0;
  logic [6:0] st_wdata_i = '0;
  logic [8:0] en_wdata_i = '0;
  logic tx_dma_ack_i = 0, rx_dma_ack_i = 0;
  logic [6:0] status_o;
  logic irq_o, tx_dma_req_o, rx_dma_req_o, rx_push_o, rx_replace_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done_flag = 0;

  logic [6:0] m_st = '0;
  logic [8:0] m_en = '0;

  always #10 clk = ~clk;  // 50 MHz

  spi_irq_unit #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .done_evt_i(done_evt_i),
    .eoq_evt_i(eoq_evt_i), .tx_uflow_evt_i(tx_uflow_evt_i),
    .tx_level_i(tx_level_i), .rx_level_i(rx_level_i), .rx_word_i(rx_word_i),
    .rx_ovwr_en_i(rx_ovwr_en_i), .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .tx_dma_ack_i(tx_dma_ack_i),
    .rx_dma_ack_i(rx_dma_ack_i), .status_o(status_o), .irq_o(irq_o),
    .tx_dma_req_o(tx_dma_req_o), .rx_dma_req_o(rx_dma_req_o),
    .rx_push_o(rx_push_o), .rx_replace_o(rx_replace_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit exp_irq();
    logic [6:0] v;
    v = m_st & m_en[6:0];
    v[0] = 1'b0;
    if (m_en[7]) v[4] = 1'b0;
    if (m_en[8]) v[6] = 1'b0;
    return |v;
  endfunction

  function automatic bit rx_full();
    return int'(rx_level_i) >= DEPTH;
  endfunction

  // reference update at a rising edge, from the inputs held during the cycle
  task automatic model_edge();
    logic [6:0] n;
    logic [6:0] clr;
    n = m_st;
    clr = st_wr_i ? st_wdata_i : 7'd0;
    n[0] = run_i;
    n[1] = (m_st[1] & ~clr[1]) | done_evt_i;
    n[2] = (m_st[2] & ~clr[2]) | eoq_evt_i;
    n[3] = (m_st[3] & ~clr[3]) | tx_uflow_evt_i;
    n[5] = (m_st[5] & ~clr[5]) | (rx_word_i & rx_full());
    if (clr[4] || (tx_dma_ack_i && m_en[4] && m_en[7])) n[4] = 1'b0;
    else n[4] = m_st[4] | (int'(tx_level_i) < DEPTH);
    if (clr[6] || (rx_dma_ack_i && m_en[6] && m_en[8])) n[6] = 1'b0;
    else n[6] = m_st[6] | (rx_level_i != '0);
    m_st = n;
    if (en_wr_i) m_en = en_wdata_i & 9'h1FE;
  endtask

  task automatic check_all();
    chk("R8 run bit", int'(status_o[0]), int'(m_st[0]));
    chk("R2 event flags", int'(status_o[3:1]), int'(m_st[3:1]));
    chk("R3 level flags", int'({status_o[6], status_o[4]}), int'({m_st[6], m_st[4]}));
    chk("R9 overflow flag", int'(status_o[5]), int'(m_st[5]));
    chk("R4 irq", int'(irq_o), int'(exp_irq()));
    chk("R5 tx dma", int'(tx_dma_req_o), int'(m_st[4] & m_en[4] & m_en[7]));
    chk("R5 rx dma", int'(rx_dma_req_o), int'(m_st[6] & m_en[6] & m_en[8]));
    chk("R9 push", int'(rx_push_o), int'(rx_word_i & ~rx_full()));
    chk("R9 replace", int'(rx_replace_o), int'(rx_word_i & rx_full() & rx_ovwr_en_i));
  endtask

  task automatic idle_inputs();
    done_evt_i = 0; eoq_evt_i = 0; tx_uflow_evt_i = 0; rx_word_i = 0;
    st_wr_i = 0; st_wdata_i = '0; en_wr_i = 0; en_wdata_i = '0;
    tx_dma_ack_i = 0; rx_dma_ack_i = 0;
  endtask

  // inputs already set; one edge, then sample at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cyc++;
    check_all();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    tx_level_i = LW'(DEPTH);
    rx_level_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 status", int'(status_o), 0);
    chk("R1 outputs", int'({irq_o, tx_dma_req_o, rx_dma_req_o, rx_push_o, rx_replace_o}), 0);
    rst_n = 1'b1;
    idle_inputs();
    step();
    chk("R1 idle after reset", int'(status_o), 0);

    // R10 / R2: pulse shows one clock later
    done_evt_i = 1; step(); done_evt_i = 0;
    chk("R10 done latency", int'(status_o[1]), 1);
    chk("R4 disabled irq", int'(irq_o), 0);
    st_wr_i = 1; st_wdata_i = 7'h00; step(); st_wr_i = 0;
    chk("R2 write zero keeps", int'(status_o[1]), 1);
    en_wr_i = 1; en_wdata_i = 9'h003; step(); en_wr_i = 0;
    chk("R4 enabled irq", int'(irq_o), 1);
    st_wr_i = 1; st_wdata_i = 7'h03; step(); st_wr_i = 0;
    chk("R2 write one clears", int'(status_o[1]), 0);
    chk("R8 run bit not cleared/irq low", int'(irq_o), 0);
    // R2: set in the same cycle as clear wins
    eoq_evt_i = 1; step();
    st_wr_i = 1; st_wdata_i = 7'h04; step(); st_wr_i = 0; eoq_evt_i = 0;
    chk("R2 set beats clear", int'(status_o[2]), 1);
    st_wr_i = 1; st_wdata_i = 7'h04; step(); st_wr_i = 0;

    // R6: selects without enables do nothing
    en_wr_i = 1; en_wdata_i = 9'h180; tx_level_i = LW'(3); step(); en_wr_i = 0;
    chk("R6 fill flag set", int'(status_o[4]), 1);
    chk("R6 no dma", int'(tx_dma_req_o), 0);
    chk("R6 no irq", int'(irq_o), 0);
    // R7: ack ignored while disabled
    tx_dma_ack_i = 1; step(); tx_dma_ack_i = 0;
    chk("R7 ack ignored", int'(status_o[4]), 1);
    en_wr_i = 1; en_wdata_i = 9'h190; step(); en_wr_i = 0;
    chk("R5 fill to dma", int'(tx_dma_req_o), 1);
    chk("R5 fill not irq", int'(irq_o), 0);
    tx_dma_ack_i = 1; step(); tx_dma_ack_i = 0;
    chk("R7 ack clears", int'(status_o[4]), 0);
    step();
    chk("R3 fill resets", int'(status_o[4]), 1);
    en_wr_i = 1; en_wdata_i = 9'h010; step(); en_wr_i = 0;
    chk("R5 fill to irq", int'(irq_o), 1);

    // R9: overflow policies
    rx_level_i = LW'(DEPTH); rx_word_i = 1; rx_ovwr_en_i = 1; step();
    chk("R9 replace full", int'(rx_replace_o), 1);
    chk("R9 no push full", int'(rx_push_o), 0);
    chk("R9 ovf set", int'(status_o[5]), 1);
    st_wr_i = 1; st_wdata_i = 7'h20; rx_word_i = 0; step(); st_wr_i = 0;
    rx_ovwr_en_i = 0; rx_word_i = 1; step();
    chk("R9 drop full", int'({rx_push_o, rx_replace_o}), 0);
    chk("R9 ovf set drop", int'(status_o[5]), 1);
    rx_level_i = LW'(2); step();
    chk("R9 push room", int'(rx_push_o), 1);
    idle_inputs();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      run_i          = 1'($urandom_range(0, 1));
      done_evt_i     = ($urandom_range(0, 7) == 0);
      eoq_evt_i      = ($urandom_range(0, 7) == 0);
      tx_uflow_evt_i = ($urandom_range(0, 9) == 0);
      tx_level_i     = ($urandom_range(0, 1) != 0) ? LW'(DEPTH) : LW'($urandom_range(0, DEPTH));
      rx_level_i     = ($urandom_range(0, 2) == 0) ? LW'(0)
                     : (($urandom_range(0, 1) != 0) ? LW'(DEPTH) : LW'($urandom_range(0, DEPTH)));
      rx_word_i      = 1'($urandom_range(0, 1));
      rx_ovwr_en_i   = 1'($urandom_range(0, 1));
      st_wr_i        = ($urandom_range(0, 3) == 0);
      st_wdata_i     = 7'($urandom());
      en_wr_i        = ($urandom_range(0, 15) == 0);
      en_wdata_i     = 9'($urandom());
      tx_dma_ack_i   = ($urandom_range(0, 2) == 0);
      rx_dma_ack_i   = ($urandom_range(0, 2) == 0);
      step();
    end
    finish_run();
  end
endmodule